// File: doc/BRIEF.md
# Repetition-Coded Fault-Detecting Logic Gadgets

This block gives a fault-aware logic layer for circuits in which any single wire may be pinned low, pinned high or inverted. Each logical bit travels as a bundle of `2*M` wires. A valid bundle has every wire equal: all low means logical 0 and all high means logical 1. Every other pattern counts as a fault. Any gadget that sees a faulty input does not compute with it. It drives one fixed error word, with the low half of its wires at 0 and the high half at 1. That word is at least `M` wire flips away from both valid words, so a later stage cannot read it as data by accident.

The top module holds one instance of each gadget, all in parallel, and registers every result once. The gadgets are an encoder, a decoder, bundle-level AND and XOR, a NOT, and a two-bundle cascade cell. The cascade cell passes a pair of bundles on only when both are clean. Each output wire is built as a product of input literals ORed with a validity term, or as the complement of one. This keeps every stage a flat two-level function.

Top module: `rep_guard_top`

## Requirements
- R1: `enc_o` shows `enc_bit_i` copied onto all `2*M` wires, one clock after it is applied.
- R2: `dec_o` is 1 only when the `dec_i` bundle applied one clock earlier is all ones. It is 0 for the all-zero bundle and for every invalid bundle.
- R3: When `a_i` and `b_i` are both valid, `and_o` is the all-ones bundle if both are logical 1 and the all-zero bundle otherwise.
- R4: When `a_i` and `b_i` are both valid, `xor_o` is the all-ones bundle if they hold different values and the all-zero bundle if they hold the same value.
- R5: When `a_i` is valid, `not_o` is the bitwise complement of `a_i`.
- R6: If any input of the AND, XOR or NOT gadget is invalid, that gadget outputs the error word. The error word has wires `[M-1:0]` = 0 and wires `[2M-1:M]` = 1.
- R7: The cascade cell copies valid `a_i` and `b_i` to `casc_x_o` and `casc_y_o` unchanged. If either input is invalid, both outputs are the error word.
- R8: All outputs are registered with one clock of latency. While `rst_ni` is low, every bundle output is all zeros and `dec_o` is 0.
- R9: A valid bundle with between 1 and `M-1` wire faults never yields the opposite valid word at any gadget output, and a faulted logical-0 bundle never decodes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_bit_i | input | 1 | Bit to encode |
| enc_o | output | 2*M | Encoded bundle |
| dec_i | input | 2*M | Bundle to decode |
| dec_o | output | 1 | Decoded bit |
| a_i | input | 2*M | First operand bundle |
| b_i | input | 2*M | Second operand bundle |
| and_o | output | 2*M | AND gadget result |
| xor_o | output | 2*M | XOR gadget result |
| not_o | output | 2*M | NOT gadget result of `a_i` |
| casc_x_o | output | 2*M | Cascade output for `a_i` |
| casc_y_o | output | 2*M | Cascade output for `b_i` |

## Verification
The block holds no state apart from its output registers, so any fault in the validity decode or the result logic appears at the ports exactly one clock after the input that triggers it. A wrong validity decision shows up in one of two ways. It can produce an output that is neither a valid word nor the error word. It can also produce a valid word where the error word was expected, or the reverse. A wrong or split error pattern shows up as a half-inverted word, or as cascade outputs that disagree with each other. Random fault injection of fewer than `M` wires targets the one failure that matters most: a faulted bundle that reaches the opposite logical value.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [0:0] {
    RG_OP_AND = 1'b0,
    RG_OP_XOR = 1'b1
  } rg_op_e;
endpackage

// File: rtl/rg_check.sv
module rg_check #(
  parameter int M = 4,
  localparam int W = 2 * M
) (
  input  logic [W-1:0] bundle_i,
  output logic         valid_o,
  output logic         val_o
);
  logic is_one, is_zero;
  assign is_one  = &bundle_i;
  assign is_zero = ~|bundle_i;
  assign valid_o = is_one | is_zero;
  assign val_o   = is_one;
endmodule

// File: rtl/rg_gate.sv
module rg_gate
  import rg_pkg::*;
#(
  parameter int     M  = 4,
  parameter rg_op_e OP = RG_OP_AND,
  localparam int    W  = 2 * M
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  logic a_ok, a_val, b_ok, b_val, ok, res;

  rg_check #(.M(M)) u_chk_a (.bundle_i(a_i), .valid_o(a_ok), .val_o(a_val));
  rg_check #(.M(M)) u_chk_b (.bundle_i(b_i), .valid_o(b_ok), .val_o(b_val));

  assign ok = a_ok & b_ok;

  if (OP == RG_OP_AND) begin : g_and
    assign res = a_val & b_val;
  end else begin : g_xor
    assign res = a_val ^ b_val;
  end

  // low half falls to 0 and high half rises to 1 on any invalid input
  for (genvar j = 0; j < W; j++) begin : g_wire
    if (j < M) begin : g_lo
      assign y_o[j] = res & ok;
    end else begin : g_hi
      assign y_o[j] = res | ~ok;
    end
  end
endmodule

// File: rtl/rg_inv.sv
module rg_inv #(
  parameter int  M = 4,
  localparam int W = 2 * M
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_o
);
  logic ok, val;

  rg_check #(.M(M)) u_chk (.bundle_i(a_i), .valid_o(ok), .val_o(val));

  for (genvar j = 0; j < W; j++) begin : g_wire
    if (j < M) begin : g_lo
      assign y_o[j] = ~val & ok;
    end else begin : g_hi
      assign y_o[j] = ~(val & ok);
    end
  end
endmodule

// File: rtl/rg_cascade.sv
module rg_cascade #(
  parameter int  M = 4,
  localparam int W = 2 * M
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);
  logic a_ok, a_val, b_ok, b_val, ok;

  rg_check #(.M(M)) u_chk_a (.bundle_i(a_i), .valid_o(a_ok), .val_o(a_val));
  rg_check #(.M(M)) u_chk_b (.bundle_i(b_i), .valid_o(b_ok), .val_o(b_val));

  assign ok = a_ok & b_ok;

  for (genvar j = 0; j < W; j++) begin : g_wire
    if (j < M) begin : g_lo
      assign x_o[j] = a_val & ok;
      assign y_o[j] = b_val & ok;
    end else begin : g_hi
      assign x_o[j] = a_val | ~ok;
      assign y_o[j] = b_val | ~ok;
    end
  end
endmodule

// File: rtl/rep_guard_top.sv
module rep_guard_top
  import rg_pkg::*;
#(
  parameter int  M = 4,
  localparam int W = 2 * M
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enc_bit_i,
  output logic [W-1:0] enc_o,
  input  logic [W-1:0] dec_i,
  output logic         dec_o,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] not_o,
  output logic [W-1:0] casc_x_o,
  output logic [W-1:0] casc_y_o
);
  localparam logic [W-1:0] ERR = {{M{1'b1}}, {M{1'b0}}};
  localparam int NBIN = 2;

  logic [W-1:0] enc_d, not_d, cx_d, cy_d;
  logic [W-1:0] bin_d [NBIN];
  logic         dec_ok, dec_val, dec_d;

  assign enc_d = {W{enc_bit_i}};

  rg_check #(.M(M)) u_dec (.bundle_i(dec_i), .valid_o(dec_ok), .val_o(dec_val));
  assign dec_d = dec_val & dec_ok;

  for (genvar g = 0; g < NBIN; g++) begin : g_bin
    rg_gate #(.M(M), .OP(rg_op_e'(g))) u_gate (
      .a_i(a_i), .b_i(b_i), .y_o(bin_d[g])
    );
  end

  rg_inv #(.M(M)) u_inv (.a_i(a_i), .y_o(not_d));

  rg_cascade #(.M(M)) u_casc (.a_i(a_i), .b_i(b_i), .x_o(cx_d), .y_o(cy_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_o    <= '0;
      dec_o    <= 1'b0;
      and_o    <= '0;
      xor_o    <= '0;
      not_o    <= '0;
      casc_x_o <= '0;
      casc_y_o <= '0;
    end else begin
      enc_o    <= enc_d;
      dec_o    <= dec_d;
      and_o    <= bin_d[RG_OP_AND];
      xor_o    <= bin_d[RG_OP_XOR];
      not_o    <= not_d;
      casc_x_o <= cx_d;
      casc_y_o <= cy_d;
    end
  end

  // assertions
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  function automatic logic in_code(input logic [W-1:0] v);
    return (v == '0) || (v == '1) || (v == ERR);
  endfunction

  a_r1_enc_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> enc_o == {W{$past(enc_bit_i)}});

  a_r2_dec_invalid_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !$past((dec_i == '0) || (dec_i == '1)) |-> !dec_o);

  a_r5_not_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past((a_i == '0) || (a_i == '1)) |-> not_o == ~$past(a_i));

  a_r6_code_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_code(and_o) && in_code(xor_o) && in_code(not_o));

  a_r7_casc_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc_x_o == ERR) == (casc_y_o == ERR));

  a_r9_casc_no_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(a_i == '0) |-> casc_x_o != '1);
endmodule

// File: tb/tb_rep_guard_top.sv
module tb_rep_guard_top;
  localparam int M = 4;
  localparam int W = 2 * M;
  localparam logic [W-1:0] ERR = {{M{1'b1}}, {M{1'b0}}};
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_bit;
  logic [W-1:0] enc_o, dec_i, a, b, and_o, xor_o, not_o, cx, cy;
  logic dec_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rep_guard_top #(.M(M)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enc_bit_i(enc_bit), .enc_o(enc_o),
    .dec_i(dec_i), .dec_o(dec_o), .a_i(a), .b_i(b), .and_o(and_o),
    .xor_o(xor_o), .not_o(not_o), .casc_x_o(cx), .casc_y_o(cy)
  );

  function automatic logic is_valid(input logic [W-1:0] v);
    return (v == '0) || (v == ONES);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic eb, input logic [W-1:0] d, input logic [W-1:0] av,
                       input logic [W-1:0] bv);
    @(negedge clk);
    enc_bit = eb; dec_i = d; a = av; b = bv;
    @(negedge clk);
  endtask

  task automatic check_gadgets(input string tag);
    logic [W-1:0] e_and, e_xor, e_not, e_cx, e_cy;
    logic ok;
    ok = is_valid(a) && is_valid(b);
    e_and = ok ? ((a[0] & b[0]) ? ONES : '0) : ERR;
    e_xor = ok ? ((a[0] ^ b[0]) ? ONES : '0) : ERR;
    e_not = is_valid(a) ? ~a : ERR;
    e_cx  = ok ? a : ERR;
    e_cy  = ok ? b : ERR;
    chk({tag, " R3 and"}, and_o, e_and);
    chk({tag, " R4 xor"}, xor_o, e_xor);
    chk({tag, " R5 not"}, not_o, e_not);
    chk({tag, " R7 casc_x"}, cx, e_cx);
    chk({tag, " R7 casc_y"}, cy, e_cy);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R8 reset enc", enc_o, '0);
    chk("R8 reset and", and_o, '0);
    chk("R8 reset not", not_o, '0);
    chk("R8 reset casc", cx | cy, '0);
    chk("R8 reset dec", W'(dec_o), '0);
  endtask

  task automatic t_encode;
    apply(1'b1, '0, '0, '0);
    chk("R1 enc one", enc_o, ONES);
    apply(1'b0, '0, '0, '0);
    chk("R1 enc zero", enc_o, '0);
  endtask

  task automatic t_decode;
    apply(1'b0, ONES, '0, '0);
    chk("R2 dec ones", W'(dec_o), W'(1));
    apply(1'b0, '0, '0, '0);
    chk("R2 dec zeros", W'(dec_o), '0);
    apply(1'b0, ERR, '0, '0);
    chk("R2 dec err word", W'(dec_o), '0);
    apply(1'b0, ONES ^ W'(1), '0, '0);
    chk("R2 dec one wire low", W'(dec_o), '0);
  endtask

  task automatic t_valid_ops;
    for (int i = 0; i < 4; i++) begin
      apply(1'b0, '0, i[0] ? ONES : '0, i[1] ? ONES : '0);
      check_gadgets("valid");
    end
  endtask

  task automatic t_invalid;
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] v, w;
      v = W'($urandom);
      if (is_valid(v)) v = W'(1) << (i % W);
      w = (i % 3 == 0) ? W'($urandom) : ((i % 2) ? ONES : '0);
      if (i % 2) apply(1'b0, '0, v, w);
      else       apply(1'b0, '0, w, v);
      check_gadgets("R6 invalid");
    end
  endtask

  task automatic t_faults;
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] base, f, bv;
      logic [W-1:0] opp_not;
      int k;
      base = (i % 2) ? ONES : '0;
      f = base;
      k = 1 + ($urandom % (M - 1));
      for (int n = 0; n < k; n++) begin
        int p, kind;
        p = $urandom % W;
        kind = $urandom % 3;
        if (kind == 0) f[p] = 1'b0;
        else if (kind == 1) f[p] = 1'b1;
        else f[p] = ~f[p];
      end
      bv = ($urandom % 2) ? ONES : '0;
      apply(1'b0, base == '0 ? f : '0, f, bv);
      check_gadgets("R9 fault");
      opp_not = base;
      if (f != base) begin
        chk("R9 not not opposite", W'(not_o == opp_not), '0);
        chk("R9 casc not opposite", W'(cx == ~base), '0);
      end
      if (base == '0) chk("R9 dec faulted zero", W'(dec_o), '0);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    enc_bit = 1'b0; dec_i = '0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_encode;
    t_decode;
    t_valid_ops;
    t_invalid;
    t_faults;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule